// File: doc/BRIEF.md
# Buffered-Compare Event Timer

A 16-bit up-counter with three compare channels. Each channel has a compare register that software can read and write. The match logic does not compare against that register directly. It compares against a private buffer copy. The buffer takes a new value from the register only while the counter is stopped, or on the increment that wraps the counter from 0xFFFF to 0x0000. A write made during a count period therefore takes effect at the start of the next period and never part-way through one.

A counter step happens on a count enable. The enable comes from one of eight power-of-two taps of a free-running prescaler, or from an external event pin. The event pin passes through a two-flop synchroniser and then an edge detector, and the valid edge can be programmed. A run bit starts and stops the counter. Each channel raises a one-clock interrupt pulse when the counter steps onto that channel's buffered value.

Top module: `bcmp_timer`

## Requirements
- R1: After reset, count_o is 0, irq_o is 0, and every register reads 0x0000.
- R2: The control register is at address 0, with run in bit 0, tap select in bits 3:1, external source in bit 4 and edge mode in bits 6:5. The compare register of channel k is at address k, for k = 1 to 3. A read returns the last value written. Any other address reads 0x0000. The buffers cannot be reached from the bus.
- R3: While run is 1, each count enable raises count_o by exactly one, and 0xFFFF wraps to 0x0000.
- R4: While run is 0, count_o holds its value and is not cleared.
- R5: With the external source bit at 0 and tap select n, the counter steps once every 2^n clocks.
- R6: With the external source bit at 1, the synchronised event pin drives the count. Edge mode 0 never counts, 1 counts rising edges, 2 counts falling edges, and 3 counts both edges.
- R7: A channel's buffer loads from its compare register on every clock in which the counter is stopped.
- R8: A compare write made while the counter runs has no effect on matching until after the next wrap. At that wrap the buffer takes the new value.
- R9: irq_o[k-1] is high for one clock, in the cycle in which count_o first shows channel k's buffered value after an increment. It is never high while the counter is stopped.
- R10: The three channels match independently, each against its own buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address for reads and writes |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i (combinational) |
| evt_i | input | 1 | External event pin (asynchronous) |
| irq_o | output | 3 | Compare-match pulses; bit k-1 belongs to channel k |
| count_o | output | 16 | Current counter value |

## Verification
The checker assumes a compare register is not rewritten in a way that makes the buffer hit the new counter value in the cycle straight after a match. It also assumes that the event pin holds each level for longer than two clocks, so that the synchroniser resolves every edge. The bench holds each event level for four clocks. It writes compare values only when the counter is stopped or when the counter is well away from those values, and it reads the counter only at the clock edge farthest from any change.

// File: rtl/bcmp_pkg.sv
package bcmp_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_mode_e;

  localparam int unsigned ADDR_CTRL = 0;
endpackage

// File: rtl/bcmp_prescaler.sv
module bcmp_prescaler #(
  parameter int unsigned NUM_TAPS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  output logic [NUM_TAPS-1:0] tick_o
);
  localparam int unsigned PW = (NUM_TAPS > 1) ? NUM_TAPS - 1 : 1;

  logic [PW-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_q + 1'b1;
  end

  // tap k pulses once every 2^k clocks
  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
    if (k == 0) begin : g_base
      assign tick_o[k] = 1'b1;
    end else begin : g_div
      assign tick_o[k] = &div_q[k-1:0];
    end
  end
endmodule

// File: rtl/bcmp_edge_det.sv
module bcmp_edge_det
  import bcmp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       evt_i,
  input  edge_mode_e mode_i,
  output logic       pulse_o
);
  logic [2:0] sh_q;  // [0],[1] synchroniser, [2] previous level
  logic       rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[1:0], evt_i};
  end

  assign rise = sh_q[1] & ~sh_q[2];
  assign fall = ~sh_q[1] & sh_q[2];

  always_comb begin
    unique case (mode_i)
      EDGE_RISE: pulse_o = rise;
      EDGE_FALL: pulse_o = fall;
      EDGE_BOTH: pulse_o = rise | fall;
      default:   pulse_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bcmp_channel.sv
module bcmp_channel #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             load_i,
  input  logic             hit_i,
  output logic [CNT_W-1:0] buf_o,
  output logic             irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_o <= '0;
      irq_o <= 1'b0;
    end else begin
      if (load_i) buf_o <= cmp_i;
      irq_o <= hit_i;
    end
  end
endmodule

// File: rtl/bcmp_timer.sv
module bcmp_timer
  import bcmp_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned NUM_CH   = 3,
  parameter int unsigned NUM_TAPS = 8,
  parameter int unsigned ADDR_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  input  logic              evt_i,
  output logic [NUM_CH-1:0] irq_o,
  output logic [CNT_W-1:0]  count_o
);
  localparam int unsigned TAP_W  = (NUM_TAPS > 1) ? $clog2(NUM_TAPS) : 1;
  localparam int unsigned EXT_B  = TAP_W + 1;
  localparam int unsigned EDGE_L = TAP_W + 2;
  localparam int unsigned EDGE_H = TAP_W + 3;

  logic                           run_q, ext_q;
  logic [TAP_W-1:0]               tap_q;
  edge_mode_e                     edge_q;
  logic [NUM_CH-1:0][CNT_W-1:0]   cmp_q;
  logic [NUM_CH-1:0][CNT_W-1:0]   buf_all;
  logic [NUM_CH-1:0]              hit;
  logic [NUM_TAPS-1:0]            tick;
  logic                           evt_pulse, cnt_en, wrap, load;
  logic [CNT_W-1:0]               cnt_q, cnt_nxt;

  // control register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      ext_q  <= 1'b0;
      tap_q  <= '0;
      edge_q <= EDGE_NONE;
    end else if (wr_en_i && addr_i == ADDR_W'(ADDR_CTRL)) begin
      run_q  <= wdata_i[0];
      tap_q  <= wdata_i[TAP_W:1];
      ext_q  <= wdata_i[EXT_B];
      edge_q <= edge_mode_e'(wdata_i[EDGE_H:EDGE_L]);
    end
  end

  // compare registers
  for (genvar c = 0; c < NUM_CH; c++) begin : g_cmp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        cmp_q[c] <= '0;
      else if (wr_en_i && addr_i == ADDR_W'(c + 1))
        cmp_q[c] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(ADDR_CTRL)) begin
      rdata_o[0]             = run_q;
      rdata_o[TAP_W:1]       = tap_q;
      rdata_o[EXT_B]         = ext_q;
      rdata_o[EDGE_H:EDGE_L] = edge_q;
    end
    for (int c = 0; c < NUM_CH; c++)
      if (addr_i == ADDR_W'(c + 1)) rdata_o = cmp_q[c];
  end

  bcmp_prescaler #(.NUM_TAPS(NUM_TAPS)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  bcmp_edge_det u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt_i),
    .mode_i  (edge_q),
    .pulse_o (evt_pulse)
  );

  assign cnt_en  = run_q & (ext_q ? evt_pulse : tick[tap_q]);
  assign cnt_nxt = cnt_q + 1'b1;
  assign wrap    = cnt_en & (&cnt_q);
  assign load    = ~run_q | wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nxt;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    // on a wrap the fresh compare value is what the new period matches against
    assign hit[c] = cnt_en & (cnt_nxt == (load ? cmp_q[c] : buf_all[c]));

    bcmp_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cmp_i  (cmp_q[c]),
      .load_i (load),
      .hit_i  (hit[c]),
      .buf_o  (buf_all[c]),
      .irq_o  (irq_o[c])
    );
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/bcmp_timer_chk.sv
module bcmp_timer_chk #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned NUM_CH = 3
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         run_i,
  input logic                         ext_i,
  input logic [1:0]                   edge_i,
  input logic [CNT_W-1:0]             count_i,
  input logic [NUM_CH-1:0]            irq_i,
  input logic [NUM_CH-1:0][CNT_W-1:0] buf_i
);
  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i != $past(count_i)) |-> (count_i == CNT_W'($past(count_i) + 1'b1))); // R3

  AST_STOP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (count_i == $past(count_i))); // R4

  AST_NO_EDGE_NO_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && ext_i && edge_i == 2'd0) |=> (count_i == $past(count_i))); // R6

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    AST_IRQ_ON_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_i[c] |-> (count_i == buf_i[c])); // R9

    AST_IRQ_AFTER_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_i[c] |-> (count_i != $past(count_i))); // R9

    AST_BUF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (buf_i[c] != $past(buf_i[c])) |-> (!$past(run_i) || count_i == '0)); // R8
  end
endmodule

bind bcmp_timer bcmp_timer_chk #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .run_i   (run_q),
  .ext_i   (ext_q),
  .edge_i  (edge_q),
  .count_i (count_o),
  .irq_i   (irq_o),
  .buf_i   (buf_all)
);

// File: tb/tb_bcmp_timer.sv
module tb_bcmp_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        evt = 1'b0;
  logic [2:0]  irq;
  logic [15:0] count;
  int          n_chk = 0, n_bad = 0, cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bcmp_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt), .irq_o(irq), .count_o(count)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic wait_count(input logic [15:0] v);
    for (int n = 0; n < 70000 && count !== v; n++) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    check("R1 count", count, 0);
    check("R1 irq", irq, 0);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d); check("R1 reg", d, 0);
    end
  endtask

  task automatic t_regs();
    logic [15:0] d;
    wr(3'd1, 16'h1234); wr(3'd2, 16'hABCD); wr(3'd0, 16'h006E);
    rd(3'd1, d); check("R2 cmp1", d, 16'h1234);
    rd(3'd2, d); check("R2 cmp2", d, 16'hABCD);
    rd(3'd0, d); check("R2 ctrl", d, 16'h006E);
    rd(3'd6, d); check("R2 unmapped", d, 0);
    check("R4 stopped count", count, 0);
    wr(3'd0, 16'h0000);
  endtask

  task automatic t_match();
    wr(3'd1, 16'd5); wr(3'd2, 16'd7); wr(3'd3, 16'd9);
    idle(2);
    wr(3'd0, 16'h0001);
    wait_count(16'd5); check("R9 ch1 at 5", irq, 3'b001);
    wait_count(16'd6); check("R9 none at 6", irq, 3'b000);
    wait_count(16'd7); check("R10 ch2 at 7", irq, 3'b010);
    wait_count(16'd9); check("R10 ch3 at 9", irq, 3'b100);
  endtask

  task automatic t_buffered();
    wr(3'd1, 16'd20);
    wait_count(16'd20); check("R8 old buffer kept", irq, 3'b000);
    wait_count(16'hFFFF); check("R3 reach max", count, 16'hFFFF);
    @(negedge clk); check("R3 wrap", count, 0);
    wait_count(16'd5); check("R8 old value gone", irq, 3'b000);
    wait_count(16'd7); check("R10 ch2 again", irq, 3'b010);
    wait_count(16'd20); check("R8 new value after wrap", irq, 3'b001);
  endtask

  task automatic t_stop();
    logic [15:0] c0;
    wr(3'd0, 16'h0000);
    c0 = count;
    idle(10);
    check("R4 hold", count, c0);
    check("R9 no irq stopped", irq, 0);
    wr(3'd1, c0 + 16'd10);
    idle(2);
    wr(3'd0, 16'h0001);
    wait_count(c0 + 16'd10); check("R7 loaded while stopped", irq, 3'b001);
  endtask

  task automatic interval(input logic [15:0] ctrl, input int exp, input string req);
    logic [15:0] p;
    int t0;
    wr(3'd0, ctrl);
    p = count;
    for (int n = 0; n < 400 && count == p; n++) @(negedge clk);
    p = count; t0 = cyc;
    for (int n = 0; n < 400 && count == p; n++) @(negedge clk);
    check(req, cyc - t0, exp);
  endtask

  task automatic ext_mode(input logic [1:0] m, input int exp, input string req);
    logic [15:0] c0;
    wr(3'd0, {9'd0, m, 1'b1, 3'd0, 1'b1});
    idle(5);
    c0 = count;
    for (int i = 0; i < 3; i++) begin
      evt = 1'b1; idle(4);
      evt = 1'b0; idle(4);
    end
    idle(5);
    check(req, 32'(count - c0), exp);
  endtask

  initial begin
    #(150000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
  end

  initial begin
    idle(3);
    t_reset();
    rst_n = 1'b1;
    idle(2);
    check("R1 after release", count, 0);
    t_regs();
    t_match();
    t_buffered();
    t_stop();
    interval(16'h0007, 8, "R5 tap3");
    interval(16'h000F, 128, "R5 tap7");
    ext_mode(2'd1, 3, "R6 rising");
    ext_mode(2'd2, 3, "R6 falling");
    ext_mode(2'd3, 6, "R6 both");
    ext_mode(2'd0, 0, "R6 none");
    summary();
  end
endmodule